// File: doc/BRIEF.md
# Packet Page Allocator and Queues

This block keeps track of a small pool of fixed-size packet buffer pages for a network controller. An allocation bitmask records which pages are in use. Three short queues of page numbers sit beside it: pages waiting to be transmitted, pages whose transmission has finished, and pages holding received frames. A host-written 3-bit command drives the allocator and the queues. A receive path asks for pages on its own, and a transmit path drains the pending queue whenever transmission is enabled.

Every result is held in a register and shown on the ports. This covers the transmit allocation result, the heads of the receive and completion queues, and the number of pages in use. The block also drives four interrupt status bits: allocation done, frame received, transmit done and transmit queue empty. An empty queue head and a failed allocation both read as the value 0x80. A transmit allocation that fails stays pending and is granted automatically as soon as any page is released.

Within one clock the sources act in a fixed order: first the transmit acknowledge, then the host command, then the receive request, then one transmit step. Each source sees the state left by the ones before it.

Top module: `pkt_page_mgr`

## Requirements
- R1: An allocate command (cmd_op 1) grants the lowest-numbered free page. alloc_result shows that page number, st_alloc goes high, and pages_used reports how many pages are allocated.
- R2: When all pages are taken, an allocate command leaves alloc_result at 0x80 and st_alloc low, and the request stays pending. The next release of any page grants the lowest free page in that same cycle: alloc_result shows it and st_alloc rises.
- R3: Commands are sampled when cmd_valid is high. The codes are 0 no-op, 1 allocate, 2 allocator reset, 3 receive pop, 4 receive pop and release, 5 release sel_page, 6 enqueue sel_page for transmit, and 7 clear the transmit queues. Code 0 changes no output.
- R4: Code 2 frees every page and empties all three queues. alloc_result becomes 0 and pages_used becomes 0.
- R5: Code 3 removes the receive queue head. st_rcv stays high if entries remain and goes low when the queue is left empty. Code 4 does the same and also frees the page that was at the head.
- R6: A pulse on rx_push takes the lowest free page, appends it to the receive queue and sets st_rcv. When no page is free, the request is dropped. rx_head shows the queue head, or 0x80 when the queue is empty.
- R7: Code 6 appends sel_page to the transmit queue. It is ignored when that queue already holds 4 entries. tx_empty is high whenever the transmit queue is empty.
- R8: While tx_en is high, one page leaves the head of the transmit queue per clock and is shown on tx_fire and tx_page. With auto_rel high, that page is freed. Otherwise it is appended to the completion queue if that queue holds fewer than 4 entries. done_head shows the completion head (0x80 when empty), and tx_done is high while the completion queue is non-empty.
- R9: A pulse on ack_tx removes one entry from the completion queue.
- R10: Code 7 empties both the transmit queue and the completion queue, and leaves page allocation unchanged.
- R11: After reset, alloc_result is 0, both queue heads read 0x80, pages_used is 0, tx_empty is high, and all other status bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| sel_page | input | 2 | Page number used by release and enqueue |
| rx_push | input | 1 | Receive path requests a page |
| tx_en | input | 1 | Transmit enable |
| auto_rel | input | 1 | Free pages once they are transmitted |
| ack_tx | input | 1 | Acknowledge transmit done (pops completion queue) |
| alloc_result | output | 8 | Last transmit allocation, 0x80 if failed or pending |
| rx_head | output | 8 | Receive queue head, 0x80 if empty |
| done_head | output | 8 | Completion queue head, 0x80 if empty |
| pages_used | output | 3 | Count of allocated pages |
| st_alloc | output | 1 | Allocation-done status |
| st_rcv | output | 1 | Receive status |
| tx_empty | output | 1 | Transmit queue empty |
| tx_done | output | 1 | Completion queue non-empty |
| tx_fire | output | 1 | A page was sent in the last cycle |
| tx_page | output | 2 | Page number sent |

## Verification
Every output comes from a register, so each result appears at the first rising edge that samples the stimulus. None takes longer. The bench changes inputs on the falling edge and reads outputs on the next falling edge. That point lies half a period after the edge that updated them. The bench drives every stimulus, directed or random, into a reference model that applies the same fixed in-cycle ordering. It compares all outputs against that model after every step, and adds explicit constant checks at the corner cases.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  localparam logic [7:0] SENTINEL = 8'h80;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_ALLOC    = 3'd1,
    OP_RESET    = 3'd2,
    OP_RX_POP   = 3'd3,
    OP_RX_FREE  = 3'd4,
    OP_RELEASE  = 3'd5,
    OP_TX_PUSH  = 3'd6,
    OP_TX_CLEAR = 3'd7
  } mmu_op_e;
endpackage

// File: rtl/ppa_popcount.sv
module ppa_popcount #(
  parameter int W  = 4,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < W; i++) begin
      count_o = count_o + {{(CW-1){1'b0}}, bits_i[i]};
    end
  end
endmodule

// File: rtl/ppa_head_port.sv
module ppa_head_port #(
  parameter int PW = 2,
  parameter int CW = 3
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [PW-1:0] head_i,
  output logic [7:0]    head_o
);
  import ppa_pkg::*;
  assign head_o = (cnt_i == '0) ? SENTINEL : {{(8-PW){1'b0}}, head_i};
endmodule

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr #(
  parameter int PAGES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [1:0] sel_page,
  input  logic       rx_push,
  input  logic       tx_en,
  input  logic       auto_rel,
  input  logic       ack_tx,
  output logic [7:0] alloc_result,
  output logic [7:0] rx_head,
  output logic [7:0] done_head,
  output logic [2:0] pages_used,
  output logic       st_alloc,
  output logic       st_rcv,
  output logic       tx_empty,
  output logic       tx_done,
  output logic       tx_fire,
  output logic [1:0] tx_page
);
  import ppa_pkg::*;

  localparam int PW = $clog2(PAGES);
  localparam int CW = $clog2(PAGES + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(PAGES);
  localparam logic [CW-1:0] ONE      = CW'(1);

  typedef struct packed {
    logic [PAGES-1:0] mask;
    logic [7:0]       res;
    logic             st;
  } alloc_t;

  // state registers
  alloc_t          alc_q, alc_n;
  logic [PW-1:0]   txq_q [PAGES];
  logic [PW-1:0]   txq_n [PAGES];
  logic [PW-1:0]   dnq_q [PAGES];
  logic [PW-1:0]   dnq_n [PAGES];
  logic [PW-1:0]   rxq_q [PAGES];
  logic [PW-1:0]   rxq_n [PAGES];
  logic [CW-1:0]   txc_q, txc_n, dnc_q, dnc_n, rxc_q, rxc_n;
  logic            rcv_q, rcv_n, fire_q, fire_n;
  logic [PW-1:0]   fpg_q, fpg_n, pick_n;

  function automatic logic [PW-1:0] first_free(input logic [PAGES-1:0] m);
    logic [PW-1:0] r;
    r = '0;
    for (int i = PAGES - 1; i >= 0; i--) begin
      if (!m[i]) r = PW'(i);
    end
    return r;
  endfunction

  // free a page, then serve a pending transmit allocation
  function automatic alloc_t free_page(input alloc_t a, input logic [PW-1:0] pg);
    alloc_t r;
    logic [PW-1:0] f;
    r = a;
    r.mask[pg] = 1'b0;
    if (r.res == SENTINEL && !(&r.mask)) begin
      f = first_free(r.mask);
      r.mask[f] = 1'b1;
      r.res = {{(8-PW){1'b0}}, f};
      r.st = 1'b1;
    end
    return r;
  endfunction

  // next state: acknowledge, command, receive, transmit step
  always_comb begin
    alc_n  = alc_q;
    txq_n  = txq_q;  txc_n = txc_q;
    dnq_n  = dnq_q;  dnc_n = dnc_q;
    rxq_n  = rxq_q;  rxc_n = rxc_q;
    rcv_n  = rcv_q;
    fire_n = 1'b0;
    fpg_n  = fpg_q;
    pick_n = '0;

    if (ack_tx && dnc_n != '0) begin
      for (int i = 0; i < PAGES - 1; i++) dnq_n[i] = dnq_n[i+1];
      dnc_n = dnc_n - ONE;
    end

    if (cmd_valid) begin
      unique case (mmu_op_e'(cmd_op))
        OP_ALLOC: begin
          alc_n.res = SENTINEL;
          alc_n.st  = 1'b0;
          if (!(&alc_n.mask)) begin
            pick_n = first_free(alc_n.mask);
            alc_n.mask[pick_n] = 1'b1;
            alc_n.res = {{(8-PW){1'b0}}, pick_n};
            alc_n.st  = 1'b1;
          end
        end
        OP_RESET: begin
          alc_n.mask = '0;
          alc_n.res  = '0;
          txc_n = '0;
          dnc_n = '0;
          rxc_n = '0;
        end
        OP_RX_POP, OP_RX_FREE: begin
          if (rxc_n != '0) begin
            if (mmu_op_e'(cmd_op) == OP_RX_FREE) alc_n = free_page(alc_n, rxq_n[0]);
            for (int i = 0; i < PAGES - 1; i++) rxq_n[i] = rxq_n[i+1];
            rxc_n = rxc_n - ONE;
          end
          rcv_n = (rxc_n != '0);
        end
        OP_RELEASE: alc_n = free_page(alc_n, sel_page[PW-1:0]);
        OP_TX_PUSH: begin
          if (txc_n < FULL_CNT) begin
            for (int i = 0; i < PAGES; i++) begin
              if (CW'(i) == txc_n) txq_n[i] = sel_page[PW-1:0];
            end
            txc_n = txc_n + ONE;
          end
        end
        OP_TX_CLEAR: begin
          txc_n = '0;
          dnc_n = '0;
        end
        default: ;
      endcase
    end

    if (rx_push && !(&alc_n.mask) && rxc_n < FULL_CNT) begin
      pick_n = first_free(alc_n.mask);
      alc_n.mask[pick_n] = 1'b1;
      for (int i = 0; i < PAGES; i++) begin
        if (CW'(i) == rxc_n) rxq_n[i] = pick_n;
      end
      rxc_n = rxc_n + ONE;
      rcv_n = 1'b1;
    end

    if (tx_en && txc_n != '0) begin
      fire_n = 1'b1;
      fpg_n  = txq_n[0];
      for (int i = 0; i < PAGES - 1; i++) txq_n[i] = txq_n[i+1];
      txc_n = txc_n - ONE;
      if (auto_rel) begin
        alc_n = free_page(alc_n, fpg_n);
      end else if (dnc_n < FULL_CNT) begin
        for (int i = 0; i < PAGES; i++) begin
          if (CW'(i) == dnc_n) dnq_n[i] = fpg_n;
        end
        dnc_n = dnc_n + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alc_q  <= '0;
      txc_q  <= '0;
      dnc_q  <= '0;
      rxc_q  <= '0;
      rcv_q  <= 1'b0;
      fire_q <= 1'b0;
      fpg_q  <= '0;
      for (int i = 0; i < PAGES; i++) begin
        txq_q[i] <= '0;
        dnq_q[i] <= '0;
        rxq_q[i] <= '0;
      end
    end else begin
      alc_q  <= alc_n;
      txc_q  <= txc_n;
      dnc_q  <= dnc_n;
      rxc_q  <= rxc_n;
      rcv_q  <= rcv_n;
      fire_q <= fire_n;
      fpg_q  <= fpg_n;
      for (int i = 0; i < PAGES; i++) begin
        txq_q[i] <= txq_n[i];
        dnq_q[i] <= dnq_n[i];
        rxq_q[i] <= rxq_n[i];
      end
    end
  end

  ppa_head_port #(.PW(PW), .CW(CW)) i_rx_head (
    .cnt_i (rxc_q), .head_i (rxq_q[0]), .head_o (rx_head)
  );
  ppa_head_port #(.PW(PW), .CW(CW)) i_done_head (
    .cnt_i (dnc_q), .head_i (dnq_q[0]), .head_o (done_head)
  );
  ppa_popcount #(.W(PAGES), .CW(CW)) i_used (
    .bits_i (alc_q.mask), .count_o (pages_used)
  );

  assign alloc_result = alc_q.res;
  assign st_alloc     = alc_q.st;
  assign st_rcv       = rcv_q;
  assign tx_empty     = (txc_q == '0);
  assign tx_done      = (dnc_q != '0);
  assign tx_fire      = fire_q;
  assign tx_page      = fpg_q;

  AST_GRANT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd1 && !(&alc_q.mask) |=> alloc_result < 8'h80 && st_alloc); // R1
  AST_FULL_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd1 && (&alc_q.mask) && !(tx_en && auto_rel)
    |=> alloc_result == 8'h80 && !st_alloc); // R2
  AST_RESET_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd2 && !rx_push |=> pages_used == '0 && alloc_result == 8'h00); // R4
  AST_RX_LAST_POP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd4) && rxc_q == ONE && !rx_push
    |=> rx_head == 8'h80 && !st_rcv); // R5
  AST_NO_SEND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_fire); // R8
  AST_TX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd7 |=> tx_empty && !tx_done); // R10
endmodule

// File: tb/test_pkt_page_mgr.sv
module test_pkt_page_mgr;
  localparam int NP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, rx_push = 0, tx_en = 0, auto_rel = 0, ack_tx = 0;
  logic [2:0] cmd_op = 0;
  logic [1:0] sel_page = 0;
  logic [7:0] alloc_result, rx_head, done_head;
  logic [2:0] pages_used;
  logic st_alloc, st_rcv, tx_empty, tx_done, tx_fire;
  logic [1:0] tx_page;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  int m_mask, m_res, tq[NP], tc, dq[NP], dc, rq[NP], rc, e_page;
  bit m_st, m_rcv, e_fire;

  always #4 clk = ~clk;

  pkt_page_mgr #(.PAGES(NP)) i_pkt_page_mgr (
    .clk, .rst_n, .cmd_valid, .cmd_op, .sel_page, .rx_push, .tx_en, .auto_rel,
    .ack_tx, .alloc_result, .rx_head, .done_head, .pages_used, .st_alloc,
    .st_rcv, .tx_empty, .tx_done, .tx_fire, .tx_page
  );

  function automatic int m_first();
    for (int i = 0; i < NP; i++) if (((m_mask >> i) & 1) == 0) return i;
    return -1;
  endfunction

  function automatic int m_used();
    int n = 0;
    for (int i = 0; i < NP; i++) n += (m_mask >> i) & 1;
    return n;
  endfunction

  task automatic m_free(input int pg);
    int f;
    m_mask &= ~(1 << pg);
    if (m_res == 128) begin
      f = m_first();
      if (f >= 0) begin m_mask |= 1 << f; m_res = f; m_st = 1; end
    end
  endtask

  task automatic m_reset();
    m_mask = 0; m_res = 0; tc = 0; dc = 0; rc = 0;
    m_st = 0; m_rcv = 0; e_fire = 0; e_page = 0;
  endtask

  task automatic m_apply(input bit ack, cv, input int op, sel, input bit rxp, ten, ar);
    int f;
    e_fire = 0;
    if (ack && dc > 0) begin
      for (int i = 0; i < NP - 1; i++) dq[i] = dq[i+1];
      dc--;
    end
    if (cv) begin
      case (op)
        1: begin
          m_res = 128; m_st = 0; f = m_first();
          if (f >= 0) begin m_mask |= 1 << f; m_res = f; m_st = 1; end
        end
        2: begin m_mask = 0; m_res = 0; tc = 0; dc = 0; rc = 0; end
        3, 4: begin
          if (rc > 0) begin
            if (op == 4) m_free(rq[0]);
            for (int i = 0; i < NP - 1; i++) rq[i] = rq[i+1];
            rc--;
          end
          m_rcv = (rc != 0);
        end
        5: m_free(sel);
        6: if (tc < NP) begin tq[tc] = sel; tc++; end
        7: begin tc = 0; dc = 0; end
        default: ;
      endcase
    end
    if (rxp) begin
      f = m_first();
      if (f >= 0) begin m_mask |= 1 << f; rq[rc] = f; rc++; m_rcv = 1; end
    end
    if (ten && tc > 0) begin
      e_fire = 1; e_page = tq[0];
      for (int i = 0; i < NP - 1; i++) tq[i] = tq[i+1];
      tc--;
      if (ar) m_free(e_page);
      else if (dc < NP) begin dq[dc] = e_page; dc++; end
    end
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    logic [33:0] a, e;
    a = {alloc_result, rx_head, done_head, pages_used, st_alloc, st_rcv,
         tx_empty, tx_done, tx_fire, tx_fire ? tx_page : 2'b00};
    e = {8'(m_res), (rc > 0) ? 8'(rq[0]) : 8'h80, (dc > 0) ? 8'(dq[0]) : 8'h80,
         3'(m_used()), m_st, m_rcv, tc == 0, dc != 0, e_fire,
         e_fire ? 2'(e_page) : 2'b00};
    chk(tag, a, e);
  endtask

  task automatic step(input bit ack, cv, input int op, sel, input bit rxp, ten, ar,
                      input string tag);
    ack_tx = ack; cmd_valid = cv; cmd_op = 3'(op); sel_page = 2'(sel);
    rx_push = rxp; tx_en = ten; auto_rel = ar;
    m_apply(ack, cv, op, sel, rxp, ten, ar);
    @(negedge clk);
    ack_tx = 0; cmd_valid = 0; rx_push = 0; tx_en = 0; auto_rel = 0;
    chk_all(tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int fires;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_all("R11 reset state");
    chk("R11 reset rx_head", rx_head, 8'h80);

    // R1 lowest-first allocation
    step(0, 1, 1, 0, 0, 0, 0, "R1 first alloc");
    chk("R1 page0", alloc_result, 8'h00);
    for (int k = 0; k < 3; k++) step(0, 1, 1, 0, 0, 0, 0, "R1 next alloc");
    chk("R1 page3", alloc_result, 8'h03);
    chk("R1 used", pages_used, 4);
    // R2 failure and retry on release
    step(0, 1, 1, 0, 0, 0, 0, "R2 alloc full");
    chk("R2 sentinel", alloc_result, 8'h80);
    chk("R2 no status", st_alloc, 0);
    step(0, 1, 5, 2, 0, 0, 0, "R2 release retries");
    chk("R2 retry grant", alloc_result, 8'h02);
    chk("R2 retry status", st_alloc, 1);
    // R3 no-op
    step(0, 1, 0, 1, 0, 0, 0, "R3 no-op");
    chk("R3 no-op used", pages_used, 4);
    // R6 receive dropped when full
    step(0, 0, 0, 0, 1, 0, 0, "R6 rx drop");
    chk("R6 drop head", rx_head, 8'h80);
    // R4 allocator reset
    step(0, 1, 2, 0, 0, 0, 0, "R4 reset");
    chk("R4 used", pages_used, 0);
    // R6 receive
    step(0, 0, 0, 0, 1, 0, 0, "R6 rx0");
    step(0, 0, 0, 0, 1, 0, 0, "R6 rx1");
    chk("R6 head", rx_head, 8'h00);
    chk("R6 rcv", st_rcv, 1);
    // R5 pops
    step(0, 1, 3, 0, 0, 0, 0, "R5 pop");
    chk("R5 head after pop", rx_head, 8'h01);
    step(0, 1, 4, 0, 0, 0, 0, "R5 pop free");
    chk("R5 rcv clear", st_rcv, 0);
    chk("R5 freed", pages_used, 1);
    // R7 enqueue, fifth ignored
    for (int k = 0; k < 5; k++) step(0, 1, 6, 0, 0, 0, 0, "R7 enqueue");
    chk("R7 not empty", tx_empty, 0);
    fires = 0;
    for (int k = 0; k < 5; k++) begin
      step(0, 0, 0, 0, 0, 1, 0, "R8 drain");
      fires += tx_fire;
    end
    chk("R7 full queue ignored extra", fires, 4);
    chk("R8 done head", done_head, 8'h00);
    chk("R8 tx_done", tx_done, 1);
    // R9 acknowledge
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, 0, 0, "R9 ack");
    chk("R9 done empty", done_head, 8'h80);
    // R8 auto release
    step(0, 1, 2, 0, 0, 0, 0, "R4 reset again");
    step(0, 1, 1, 0, 0, 0, 0, "R1 alloc");
    step(0, 1, 6, 0, 0, 0, 0, "R7 enqueue");
    step(0, 0, 0, 0, 0, 1, 1, "R8 auto release");
    chk("R8 fired", tx_fire, 1);
    chk("R8 auto freed", pages_used, 0);
    chk("R8 no completion", tx_done, 0);
    // R10 clear
    step(0, 1, 1, 0, 0, 0, 0, "R1 alloc");
    step(0, 1, 6, 0, 0, 0, 0, "R7 enqueue");
    step(0, 1, 6, 0, 0, 0, 0, "R7 enqueue");
    step(0, 0, 0, 0, 0, 1, 0, "R8 one sent");
    step(0, 1, 7, 0, 0, 0, 0, "R10 clear");
    chk("R10 empty", tx_empty, 1);
    chk("R10 pages kept", pages_used, 1);

    void'($urandom(32'd20240611));
    for (int k = 0; k < 600; k++) begin
      step(($urandom % 5) == 0, ($urandom % 5) < 3, int'($urandom % 8),
           int'($urandom % 4), ($urandom % 5) == 0, ($urandom % 10) < 3,
           ($urandom % 2) == 1, "R3/R8 random mix");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule